// File: doc/BRIEF.md
# Trap Entry Controller

This block performs the state update for entering a trap on a 32-bit processor core that has a branch delay slot. The core presents a one-cycle request with a cause code. The request arrives together with a snapshot of the current program counter, machine status word, exception status word, delay-slot and immediate-prefix flags, the pending branch target, the faulting address and the access type. On the next clock edge the block presents, all at once, the values the core writes back. These are the new status word, the exception status and fault address words, the saved branch target, one link register write (index and value), the new program counter and a request to clear the pipeline flags. A one-cycle `done` strobe marks them valid.

Five causes are handled: a hardware exception, a memory translation fault, an external interrupt, a software break and a hardware break. The trap vectors sit at fixed offsets from a base address supplied at an input. The return address saved for a translation fault is rewound so that an interrupted branch, and any immediate prefix in front of it, runs again. A second translation fault that arrives while one is still being entered is unrecoverable. It raises a sticky error output.

Top module: `trap_entry_ctrl`

## Requirements
- R1: A request (`req_valid` high for one cycle) with cause 1 = hardware exception, 2 = translation fault, 3 = interrupt, 4 = software break or 5 = hardware break, if accepted, raises `done` for exactly one cycle in the cycle after the request. All write strobes and values become valid in that same cycle. Cause codes 0, 6 and 7 are ignored.
- R2: The new PC is `vec_base` + 0x20 for a hardware exception or a translation fault, `vec_base` + 0x10 for an interrupt, `vec_base` + 0x18 for a hardware break, and `br_target` for a software break.
- R3: The status word bit layout is IE = bit 1, BIP = bit 3, EIP = bit 9, UM = bit 11, UMS = bit 12, VM = bit 13, VMS = bit 14. On every entry, UMS takes the old UM and VMS takes the old VM. UM and VM are then cleared. An interrupt also clears IE. All other bits are kept.
- R4: A hardware exception or translation fault entry sets EIP. Either kind of break sets BIP.
- R5: A hardware exception writes PC+4 to link register 17. A translation fault with neither flag set writes the PC to link register 17.
- R6: For a hardware exception, the new exception status word is `cur_esr` with bit 12 replaced by `in_dslot`. For either exception kind, `btr_we` is raised with `new_btr` = `br_target` only when `in_dslot` is set.
- R7: For a translation fault, the link value is rewound from the PC as follows. It is PC−4 when `in_dslot` is set, PC−8 when `in_dslot` and `br_imm` are both set, and PC−4 when only `in_imm` is set. `in_imm` is disregarded when `in_dslot` is set.
- R8: A translation fault writes the exception status word as follows. Bits 4:0 hold a code: 16 for a protection fault or 18 for a miss (`fault_miss`), plus 1 when `acc_type` = 2 (fetch). Bit 10 is set when `acc_type` = 1 (store), bit 12 equals `in_dslot`, and all other bits are zero. `ear_we` is raised with `new_ear` = `fault_addr`.
- R9: An interrupt writes the PC to link register 14. A hardware break writes the PC to link register 16. A software break makes no link write.
- R10: `flags_clr` is raised with hardware exception and translation fault entries only. A hardware exception request is ignored when `cfg_exc_en` is low.
- R11: A translation fault request in the cycle in which a translation fault entry is signalled is not taken. It sets `fatal`, which stays high until reset.
- R12: An interrupt is accepted only when IE is set, EIP and BIP are clear, and `in_dslot` is clear.
- R13: A synchronous active-high reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_exc_en | input | 1 | Hardware exceptions supported |
| vec_base | input | XLEN | Base address of the trap vectors |
| req_valid | input | 1 | One-cycle trap request |
| req_cause | input | 3 | Trap cause code |
| cur_pc | input | XLEN | PC of the trapping instruction |
| cur_msr | input | XLEN | Current machine status word |
| cur_esr | input | XLEN | Current exception status word |
| in_dslot | input | 1 | Trap hit inside a branch delay slot |
| in_imm | input | 1 | Trap hit after an immediate prefix |
| br_imm | input | 1 | Pending branch carried an immediate prefix |
| br_target | input | XLEN | Pending branch target |
| fault_addr | input | XLEN | Faulting address |
| acc_type | input | 2 | 0 load, 1 store, 2 fetch |
| fault_miss | input | 1 | 1 miss, 0 protection fault |
| done | output | 1 | Entry complete, outputs valid |
| new_msr | output | XLEN | Status word to write |
| new_pc | output | XLEN | Program counter to jump to |
| lr_we | output | 1 | Link register write enable |
| lr_idx | output | RIDX_W | Link register index |
| lr_val | output | XLEN | Link register value |
| esr_we | output | 1 | Exception status write enable |
| new_esr | output | XLEN | Exception status value |
| ear_we | output | 1 | Fault address write enable |
| new_ear | output | XLEN | Fault address value |
| btr_we | output | 1 | Branch target save enable |
| new_btr | output | XLEN | Saved branch target |
| flags_clr | output | 1 | Clear delay-slot and prefix flags |
| fatal | output | 1 | Sticky recursive-fault error |

## Verification
Translation faults are driven with every combination of the two pipeline flags and the branch prefix, so that each rewind amount of 0, 4 and 8 bytes appears at least once. Load, store and fetch accesses are paired with protection faults and misses, which tells the four status codes and the store bit apart. Interrupts are offered with the enable off, with an exception in progress, with a break in progress and inside a delay slot. Each case must be refused on its own gating condition. The status words in the vectors set UM and VM separately, so a swapped or missing shadow copy shows up. Back-to-back translation faults exercise the sticky error and its clearing by reset.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

  typedef enum logic [2:0] {
    CAUSE_NONE  = 3'd0,
    CAUSE_HWEXC = 3'd1,
    CAUSE_XLAT  = 3'd2,
    CAUSE_IRQ   = 3'd3,
    CAUSE_SWBRK = 3'd4,
    CAUSE_HWBRK = 3'd5
  } cause_e;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_e;

  // status word bit positions; each saved copy sits one bit above its live bit
  localparam int ST_IE  = 1;
  localparam int ST_BIP = 3;
  localparam int ST_EIP = 9;
  localparam int ST_UM  = 11;
  localparam int ST_UMS = ST_UM + 1;
  localparam int ST_VM  = 13;
  localparam int ST_VMS = ST_VM + 1;

  // exception status word fields
  localparam int ES_CODE_W = 5;
  localparam int ES_STORE  = 10;
  localparam int ES_DSLOT  = 12;
  localparam logic [ES_CODE_W-1:0] CODE_PROT = 5'd16;
  localparam logic [ES_CODE_W-1:0] CODE_MISS = 5'd18;

  // vector offsets
  localparam int VOFS_IRQ   = 'h10;
  localparam int VOFS_HWBRK = 'h18;
  localparam int VOFS_EXC   = 'h20;

  // link register indices
  localparam int LR_IRQ   = 14;
  localparam int LR_HWBRK = 16;
  localparam int LR_EXC   = 17;

  localparam int INSN_BYTES = 4;

  typedef struct packed {
    logic hwexc;
    logic xlat;
    logic irq;
    logic swbrk;
    logic hwbrk;
  } sel_t;

endpackage

// File: rtl/trap_accept.sv
module trap_accept
  import trap_entry_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            req_valid,
  input  logic [2:0]      req_cause,
  input  logic [XLEN-1:0] cur_msr,
  input  logic            in_dslot,
  input  logic            cfg_exc_en,
  input  logic            fault_busy,
  output sel_t            sel,
  output logic            recursive
);

  logic irq_ok;

  always_comb begin
    irq_ok = cur_msr[ST_IE] && !cur_msr[ST_EIP] && !cur_msr[ST_BIP] && !in_dslot;
    sel = '0;
    recursive = 1'b0;
    if (req_valid) begin
      unique case (req_cause)
        CAUSE_HWEXC: sel.hwexc = cfg_exc_en;
        CAUSE_XLAT: begin
          if (fault_busy) recursive = 1'b1;
          else            sel.xlat = 1'b1;
        end
        CAUSE_IRQ:   sel.irq   = irq_ok;
        CAUSE_SWBRK: sel.swbrk = 1'b1;
        CAUSE_HWBRK: sel.hwbrk = 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/trap_status_calc.sv
module trap_status_calc
  import trap_entry_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  sel_t            sel,
  input  logic [XLEN-1:0] cur_msr,
  input  logic [XLEN-1:0] cur_esr,
  input  logic            in_dslot,
  input  logic [1:0]      acc_type,
  input  logic            fault_miss,
  output logic [XLEN-1:0] msr_nx,
  output logic [XLEN-1:0] esr_nx,
  output logic            esr_we_nx,
  output logic            ear_we_nx,
  output logic            btr_we_nx,
  output logic            fclr_nx
);

  logic                 is_exc;
  logic                 is_brk;
  logic [ES_CODE_W-1:0] code;

  always_comb begin
    is_exc = sel.hwexc | sel.xlat;
    is_brk = sel.swbrk | sel.hwbrk;

    msr_nx = cur_msr;
    msr_nx[ST_UMS] = cur_msr[ST_UM];
    msr_nx[ST_VMS] = cur_msr[ST_VM];
    msr_nx[ST_UM]  = 1'b0;
    msr_nx[ST_VM]  = 1'b0;
    if (sel.irq) msr_nx[ST_IE]  = 1'b0;
    if (is_exc)  msr_nx[ST_EIP] = 1'b1;
    if (is_brk)  msr_nx[ST_BIP] = 1'b1;

    code = (fault_miss ? CODE_MISS : CODE_PROT)
         + {{(ES_CODE_W-1){1'b0}}, (acc_type == ACC_FETCH)};

    esr_nx = '0;
    if (sel.hwexc) begin
      esr_nx = cur_esr;
      esr_nx[ES_DSLOT] = in_dslot;
    end else if (sel.xlat) begin
      esr_nx[ES_CODE_W-1:0] = code;
      esr_nx[ES_STORE]      = (acc_type == ACC_STORE);
      esr_nx[ES_DSLOT]      = in_dslot;
    end

    esr_we_nx = is_exc;
    ear_we_nx = sel.xlat;
    btr_we_nx = is_exc & in_dslot;
    fclr_nx   = is_exc;
  end

endmodule

// File: rtl/trap_target_calc.sv
module trap_target_calc
  import trap_entry_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int RIDX_W = 5
) (
  input  sel_t              sel,
  input  logic [XLEN-1:0]   vec_base,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [XLEN-1:0]   br_target,
  input  logic              in_dslot,
  input  logic              in_imm,
  input  logic              br_imm,
  output logic [XLEN-1:0]   pc_nx,
  output logic              lr_we_nx,
  output logic [RIDX_W-1:0] lr_idx_nx,
  output logic [XLEN-1:0]   lr_val_nx
);

  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  logic [XLEN-1:0] rewind;

  always_comb begin
    if (in_dslot)    rewind = br_imm ? (STEP << 1) : STEP;
    else if (in_imm) rewind = STEP;
    else             rewind = '0;

    pc_nx     = '0;
    lr_we_nx  = 1'b0;
    lr_idx_nx = '0;
    lr_val_nx = '0;
    if (sel.hwexc) begin
      pc_nx     = vec_base + XLEN'(VOFS_EXC);
      lr_we_nx  = 1'b1;
      lr_idx_nx = RIDX_W'(LR_EXC);
      lr_val_nx = cur_pc + STEP;
    end else if (sel.xlat) begin
      pc_nx     = vec_base + XLEN'(VOFS_EXC);
      lr_we_nx  = 1'b1;
      lr_idx_nx = RIDX_W'(LR_EXC);
      lr_val_nx = cur_pc - rewind;
    end else if (sel.irq) begin
      pc_nx     = vec_base + XLEN'(VOFS_IRQ);
      lr_we_nx  = 1'b1;
      lr_idx_nx = RIDX_W'(LR_IRQ);
      lr_val_nx = cur_pc;
    end else if (sel.hwbrk) begin
      pc_nx     = vec_base + XLEN'(VOFS_HWBRK);
      lr_we_nx  = 1'b1;
      lr_idx_nx = RIDX_W'(LR_HWBRK);
      lr_val_nx = cur_pc;
    end else if (sel.swbrk) begin
      pc_nx     = br_target;
    end
  end

endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
  import trap_entry_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int RIDX_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_exc_en,
  input  logic [XLEN-1:0]   vec_base,
  input  logic              req_valid,
  input  logic [2:0]        req_cause,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [XLEN-1:0]   cur_msr,
  input  logic [XLEN-1:0]   cur_esr,
  input  logic              in_dslot,
  input  logic              in_imm,
  input  logic              br_imm,
  input  logic [XLEN-1:0]   br_target,
  input  logic [XLEN-1:0]   fault_addr,
  input  logic [1:0]        acc_type,
  input  logic              fault_miss,
  output logic              done,
  output logic [XLEN-1:0]   new_msr,
  output logic [XLEN-1:0]   new_pc,
  output logic              lr_we,
  output logic [RIDX_W-1:0] lr_idx,
  output logic [XLEN-1:0]   lr_val,
  output logic              esr_we,
  output logic [XLEN-1:0]   new_esr,
  output logic              ear_we,
  output logic [XLEN-1:0]   new_ear,
  output logic              btr_we,
  output logic [XLEN-1:0]   new_btr,
  output logic              flags_clr,
  output logic              fatal
);

  sel_t              sel;
  logic              recursive;
  logic              take;
  logic              fault_busy_q;
  logic [XLEN-1:0]   msr_nx, esr_nx, pc_nx, lr_val_nx;
  logic              esr_we_nx, ear_we_nx, btr_we_nx, fclr_nx, lr_we_nx;
  logic [RIDX_W-1:0] lr_idx_nx;

  trap_accept #(.XLEN(XLEN)) u_accept (
    .req_valid  (req_valid),
    .req_cause  (req_cause),
    .cur_msr    (cur_msr),
    .in_dslot   (in_dslot),
    .cfg_exc_en (cfg_exc_en),
    .fault_busy (fault_busy_q),
    .sel        (sel),
    .recursive  (recursive)
  );

  trap_status_calc #(.XLEN(XLEN)) u_status (
    .sel        (sel),
    .cur_msr    (cur_msr),
    .cur_esr    (cur_esr),
    .in_dslot   (in_dslot),
    .acc_type   (acc_type),
    .fault_miss (fault_miss),
    .msr_nx     (msr_nx),
    .esr_nx     (esr_nx),
    .esr_we_nx  (esr_we_nx),
    .ear_we_nx  (ear_we_nx),
    .btr_we_nx  (btr_we_nx),
    .fclr_nx    (fclr_nx)
  );

  trap_target_calc #(.XLEN(XLEN), .RIDX_W(RIDX_W)) u_target (
    .sel       (sel),
    .vec_base  (vec_base),
    .cur_pc    (cur_pc),
    .br_target (br_target),
    .in_dslot  (in_dslot),
    .in_imm    (in_imm),
    .br_imm    (br_imm),
    .pc_nx     (pc_nx),
    .lr_we_nx  (lr_we_nx),
    .lr_idx_nx (lr_idx_nx),
    .lr_val_nx (lr_val_nx)
  );

  assign take = |sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      done         <= 1'b0;
      new_msr      <= '0;
      new_pc       <= '0;
      lr_we        <= 1'b0;
      lr_idx       <= '0;
      lr_val       <= '0;
      esr_we       <= 1'b0;
      new_esr      <= '0;
      ear_we       <= 1'b0;
      new_ear      <= '0;
      btr_we       <= 1'b0;
      new_btr      <= '0;
      flags_clr    <= 1'b0;
      fatal        <= 1'b0;
      fault_busy_q <= 1'b0;
    end else begin
      done         <= take;
      lr_we        <= lr_we_nx;
      esr_we       <= esr_we_nx;
      ear_we       <= ear_we_nx;
      btr_we       <= btr_we_nx;
      flags_clr    <= fclr_nx;
      fault_busy_q <= sel.xlat;
      if (recursive) fatal <= 1'b1;
      if (take) begin
        new_msr <= msr_nx;
        new_pc  <= pc_nx;
        lr_idx  <= lr_idx_nx;
        lr_val  <= lr_val_nx;
        new_esr <= esr_nx;
      end
      if (ear_we_nx) new_ear <= fault_addr;
      if (btr_we_nx) new_btr <= br_target;
    end
  end

endmodule

// File: rtl/trap_entry_ctrl_chk.sv
module trap_entry_ctrl_chk
  import trap_entry_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int RIDX_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_exc_en,
  input logic [XLEN-1:0]   vec_base,
  input logic              req_valid,
  input logic [2:0]        req_cause,
  input logic [XLEN-1:0]   cur_pc,
  input logic [XLEN-1:0]   cur_msr,
  input logic [XLEN-1:0]   cur_esr,
  input logic              in_dslot,
  input logic              in_imm,
  input logic              br_imm,
  input logic [XLEN-1:0]   br_target,
  input logic [XLEN-1:0]   fault_addr,
  input logic [1:0]        acc_type,
  input logic              fault_miss,
  input logic              done,
  input logic [XLEN-1:0]   new_msr,
  input logic [XLEN-1:0]   new_pc,
  input logic              lr_we,
  input logic [RIDX_W-1:0] lr_idx,
  input logic [XLEN-1:0]   lr_val,
  input logic              esr_we,
  input logic [XLEN-1:0]   new_esr,
  input logic              ear_we,
  input logic [XLEN-1:0]   new_ear,
  input logic              btr_we,
  input logic [XLEN-1:0]   new_btr,
  input logic              flags_clr,
  input logic              fatal
);

  p_strobes_in_done_r1: assert property (@(posedge clk) disable iff (rst)
    (lr_we | esr_we | ear_we | btr_we | flags_clr) |-> done);

  p_done_single_r1: assert property (@(posedge clk) disable iff (rst)
    (done && !$past(req_valid)) |-> 1'b0);

  p_live_bits_clear_r3: assert property (@(posedge clk) disable iff (rst)
    done |-> (!new_msr[ST_VM] && !new_msr[ST_UM]));

  p_swbrk_shadow_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_cause == CAUSE_SWBRK) |=>
      (done && new_msr[ST_VMS] == $past(cur_msr[ST_VM]) &&
       new_msr[ST_UMS] == $past(cur_msr[ST_UM]) && new_msr[ST_BIP] &&
       new_pc == $past(br_target) && !lr_we));

  p_fault_lr17_r5: assert property (@(posedge clk) disable iff (rst)
    ear_we |-> (lr_we && lr_idx == RIDX_W'(LR_EXC) && esr_we && new_msr[ST_EIP]));

  p_hwexc_off_r10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_cause == CAUSE_HWEXC && !cfg_exc_en) |=> !done);

  p_irq_gate_r12: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_cause == CAUSE_IRQ &&
     (!cur_msr[ST_IE] || cur_msr[ST_EIP] || cur_msr[ST_BIP] || in_dslot)) |=> !done);

  p_irq_vector_r2: assert property (@(posedge clk) disable iff (rst)
    (done && lr_we && lr_idx == RIDX_W'(LR_IRQ)) |->
      (new_pc == $past(vec_base) + XLEN'(VOFS_IRQ) && !new_msr[ST_IE]));

  p_fatal_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    fatal |=> fatal);

endmodule

bind trap_entry_ctrl trap_entry_ctrl_chk #(.XLEN(XLEN), .RIDX_W(RIDX_W)) u_chk (.*);

// File: tb/trap_entry_ctrl_tb.sv
module trap_entry_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 16;
  localparam logic [31:0] BASE = 32'h0000_1000;
  localparam logic [31:0] BTGT = 32'h0000_9000;
  localparam logic [31:0] ESR0 = 32'h0000_1005;

  typedef struct packed {
    logic [2:0]  cause;
    logic [31:0] pc;
    logic [31:0] msr;
    logic        dslot;
    logic        imm;
    logic        bimm;
    logic [1:0]  acc;
    logic        miss;
    logic        x_done;
    logic [31:0] x_pc;
    logic        x_lr_we;
    logic [4:0]  x_lr_idx;
    logic [31:0] x_lr_val;
    logic [31:0] x_msr;
    logic        x_esr_we;
    logic [31:0] x_esr;
    logic        x_btr_we;
    logic        x_ear_we;
    logic        x_fclr;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{3'd1, 32'h100, 32'h2002, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 32'h1020, 1'b1, 5'd17, 32'h104, 32'h4202, 1'b1, 32'h0005, 1'b0, 1'b0, 1'b1},
    '{3'd1, 32'h200, 32'h0800, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 32'h1020, 1'b1, 5'd17, 32'h204, 32'h1200, 1'b1, 32'h1005, 1'b1, 1'b0, 1'b1},
    '{3'd2, 32'h300, 32'h2800, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 32'h1020, 1'b1, 5'd17, 32'h300, 32'h5200, 1'b1, 32'h0012, 1'b0, 1'b1, 1'b1},
    '{3'd2, 32'h400, 32'h0000, 1'b1, 1'b0, 1'b0, 2'd1, 1'b0, 1'b1, 32'h1020, 1'b1, 5'd17, 32'h3FC, 32'h0200, 1'b1, 32'h1410, 1'b1, 1'b1, 1'b1},
    '{3'd2, 32'h500, 32'h0000, 1'b1, 1'b0, 1'b1, 2'd2, 1'b0, 1'b1, 32'h1020, 1'b1, 5'd17, 32'h4F8, 32'h0200, 1'b1, 32'h1011, 1'b1, 1'b1, 1'b1},
    '{3'd2, 32'h600, 32'h0000, 1'b0, 1'b1, 1'b0, 2'd2, 1'b1, 1'b1, 32'h1020, 1'b1, 5'd17, 32'h5FC, 32'h0200, 1'b1, 32'h0013, 1'b0, 1'b1, 1'b1},
    '{3'd3, 32'h700, 32'h2802, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 32'h1010, 1'b1, 5'd14, 32'h700, 32'h5000, 1'b0, 32'h0000, 1'b0, 1'b0, 1'b0},
    '{3'd3, 32'h700, 32'h0000, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0,    1'b0, 5'd0,  32'h0,   32'h0,    1'b0, 32'h0,    1'b0, 1'b0, 1'b0},
    '{3'd3, 32'h700, 32'h0202, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0,    1'b0, 5'd0,  32'h0,   32'h0,    1'b0, 32'h0,    1'b0, 1'b0, 1'b0},
    '{3'd3, 32'h700, 32'h0002, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0,    1'b0, 5'd0,  32'h0,   32'h0,    1'b0, 32'h0,    1'b0, 1'b0, 1'b0},
    '{3'd5, 32'h800, 32'h2000, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 32'h1018, 1'b1, 5'd16, 32'h800, 32'h4008, 1'b0, 32'h0,    1'b0, 1'b0, 1'b0},
    '{3'd4, 32'h900, 32'h0802, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 32'h9000, 1'b0, 5'd0,  32'h0,   32'h100A, 1'b0, 32'h0,    1'b0, 1'b0, 1'b0},
    '{3'd0, 32'h900, 32'h0002, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0,    1'b0, 5'd0,  32'h0,   32'h0,    1'b0, 32'h0,    1'b0, 1'b0, 1'b0},
    '{3'd7, 32'h900, 32'h0002, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0,    1'b0, 5'd0,  32'h0,   32'h0,    1'b0, 32'h0,    1'b0, 1'b0, 1'b0},
    '{3'd3, 32'hA00, 32'h000A, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0,    1'b0, 5'd0,  32'h0,   32'h0,    1'b0, 32'h0,    1'b0, 1'b0, 1'b0},
    '{3'd2, 32'hB00, 32'h0000, 1'b1, 1'b1, 1'b0, 2'd1, 1'b1, 1'b1, 32'h1020, 1'b1, 5'd17, 32'hAFC, 32'h0200, 1'b1, 32'h1412, 1'b1, 1'b1, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_exc_en;
  logic [31:0] vec_base;
  logic        req_valid;
  logic [2:0]  req_cause;
  logic [31:0] cur_pc, cur_msr, cur_esr, br_target, fault_addr;
  logic        in_dslot, in_imm, br_imm, fault_miss;
  logic [1:0]  acc_type;
  logic        done, lr_we, esr_we, ear_we, btr_we, flags_clr, fatal;
  logic [31:0] new_msr, new_pc, lr_val, new_esr, new_ear, new_btr;
  logic [4:0]  lr_idx;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_entry_ctrl u_dut (
    .clk(clk), .rst(rst), .cfg_exc_en(cfg_exc_en), .vec_base(vec_base),
    .req_valid(req_valid), .req_cause(req_cause), .cur_pc(cur_pc),
    .cur_msr(cur_msr), .cur_esr(cur_esr), .in_dslot(in_dslot),
    .in_imm(in_imm), .br_imm(br_imm), .br_target(br_target),
    .fault_addr(fault_addr), .acc_type(acc_type), .fault_miss(fault_miss),
    .done(done), .new_msr(new_msr), .new_pc(new_pc), .lr_we(lr_we),
    .lr_idx(lr_idx), .lr_val(lr_val), .esr_we(esr_we), .new_esr(new_esr),
    .ear_we(ear_we), .new_ear(new_ear), .btr_we(btr_we), .new_btr(new_btr),
    .flags_clr(flags_clr), .fatal(fatal)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    req_valid  = 1'b0;
    req_cause  = 3'd0;
    cur_pc     = '0;
    cur_msr    = '0;
    in_dslot   = 1'b0;
    in_imm     = 1'b0;
    br_imm     = 1'b0;
    acc_type   = 2'd0;
    fault_miss = 1'b0;
    fault_addr = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    idle_inputs();
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst        = 1'b1;
    cfg_exc_en = 1'b1;
    vec_base   = BASE;
    cur_esr    = ESR0;
    br_target  = BTGT;
    idle_inputs();
    repeat (3) @(negedge clk);

    // R13: reset clears every output
    chk("R13", "reset outputs",
        {16'h0, done, lr_we, esr_we, ear_we, btr_we, flags_clr, fatal, 9'h0},
        32'h0);
    chk("R13", "reset msr/pc", new_msr | new_pc | lr_val | new_esr | new_ear | new_btr, 32'h0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      req_valid  = 1'b1;
      req_cause  = VECS[i].cause;
      cur_pc     = VECS[i].pc;
      cur_msr    = VECS[i].msr;
      in_dslot   = VECS[i].dslot;
      in_imm     = VECS[i].imm;
      br_imm     = VECS[i].bimm;
      acc_type   = VECS[i].acc;
      fault_miss = VECS[i].miss;
      fault_addr = VECS[i].pc ^ 32'hABCD_0000;
      @(negedge clk);
      idle_inputs();
      chk("R1 R10 R12", $sformatf("vec%0d done", i), {31'h0, done}, {31'h0, VECS[i].x_done});
      chk("R9", $sformatf("vec%0d lr_we", i), {31'h0, lr_we}, {31'h0, VECS[i].x_lr_we});
      if (VECS[i].x_done) begin
        chk("R2", $sformatf("vec%0d pc", i), new_pc, VECS[i].x_pc);
        chk("R3 R4", $sformatf("vec%0d msr", i), new_msr, VECS[i].x_msr);
        chk("R10", $sformatf("vec%0d flags_clr", i), {31'h0, flags_clr}, {31'h0, VECS[i].x_fclr});
        chk("R6 R8", $sformatf("vec%0d esr_we", i), {31'h0, esr_we}, {31'h0, VECS[i].x_esr_we});
        chk("R6", $sformatf("vec%0d btr_we", i), {31'h0, btr_we}, {31'h0, VECS[i].x_btr_we});
        chk("R8", $sformatf("vec%0d ear_we", i), {31'h0, ear_we}, {31'h0, VECS[i].x_ear_we});
        if (VECS[i].x_lr_we) begin
          chk("R5 R7 R9", $sformatf("vec%0d lr_idx", i), {27'h0, lr_idx}, {27'h0, VECS[i].x_lr_idx});
          chk("R5 R7 R9", $sformatf("vec%0d lr_val", i), lr_val, VECS[i].x_lr_val);
        end
        if (VECS[i].x_esr_we)
          chk("R6 R8", $sformatf("vec%0d esr", i), new_esr, VECS[i].x_esr);
        if (VECS[i].x_btr_we)
          chk("R6", $sformatf("vec%0d btr", i), new_btr, BTGT);
        if (VECS[i].x_ear_we)
          chk("R8", $sformatf("vec%0d ear", i), new_ear, VECS[i].pc ^ 32'hABCD_0000);
      end
      @(negedge clk);
      chk("R1", $sformatf("vec%0d done one cycle", i), {31'h0, done}, 32'h0);
    end

    // R10: hardware exception ignored with support off
    cfg_exc_en = 1'b0;
    req_valid = 1'b1; req_cause = 3'd1; cur_pc = 32'h40; cur_msr = 32'h2;
    @(negedge clk);
    idle_inputs();
    chk("R10", "hwexc disabled done", {31'h0, done}, 32'h0);
    chk("R10", "hwexc disabled esr_we", {31'h0, esr_we}, 32'h0);
    cfg_exc_en = 1'b1;
    @(negedge clk);

    // R11: back-to-back translation faults
    req_valid = 1'b1; req_cause = 3'd2; cur_pc = 32'hC00; acc_type = 2'd0;
    @(negedge clk);
    chk("R11", "first fault done", {31'h0, done}, 32'h1);
    chk("R11", "no fatal yet", {31'h0, fatal}, 32'h0);
    @(negedge clk);
    idle_inputs();
    chk("R11", "second fault fatal", {31'h0, fatal}, 32'h1);
    chk("R11", "second fault not taken", {31'h0, done}, 32'h0);
    repeat (3) @(negedge clk);
    chk("R11", "fatal sticky", {31'h0, fatal}, 32'h1);
    do_reset();
    chk("R11 R13", "fatal cleared by reset", {31'h0, fatal}, 32'h0);

    // R1: fault after an idle gap is accepted normally
    @(negedge clk);
    req_valid = 1'b1; req_cause = 3'd2; cur_pc = 32'hD00; acc_type = 2'd2; fault_miss = 1'b1;
    @(negedge clk);
    idle_inputs();
    chk("R1 R8", "fault after reset esr", new_esr, 32'h13);
    chk("R11", "isolated fault no fatal", {31'h0, fatal}, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule